// File: doc/BRIEF.md
# Platform interrupt hub with claim and completion

This block collects level-sensitive interrupt lines from peripherals and routes them to the machine-mode external interrupt input of each hart. Every source has a priority. Every hart has its own enable bank, its own threshold and its own claim/completion register. A hart's interrupt line is raised while at least one source is pending, enabled for that hart, and has a priority strictly above that hart's threshold.

Software reads the claim register to learn which source to service. The read also takes ownership of that source: its pending bit is cleared, and it is held in service so that its still-asserted line cannot request again. When the handler finishes, it writes the same source number back to the same address. This releases the source, and a line that is still high becomes pending again. All registers sit on a plain 32-bit register bus. A write takes effect on the clock edge where `bus_we` is high. Read data is a combinational function of `bus_addr`, and only a read with `bus_re` high has side effects. The bus is always ready and has no back-pressure.

Top module: `irq_hub`

## Requirements
- R1: Source s has a priority register at byte offset s*4 for s in 1..31. Bits [2:0] hold the priority and upper write bits are dropped. Source 0 reads 0 whatever is written to it.
- R2: The enable word of hart h is at 0x2000 + h*0x80. Bit s enables source s for that hart. Bit 0 always reads 0.
- R3: The threshold of hart h is at 0x200000 + h*0x1000. It holds bits [2:0] of the written data.
- R4: A source is eligible for hart h only if it is pending, enabled for h, and its priority is strictly greater than h's threshold. Priority 0 is therefore never eligible.
- R5: The claim/completion register of hart h is at threshold address + 4. Its read data is the eligible source with the highest priority, with the lowest source number winning ties. It reads 0 when nothing is eligible.
- R6: A read of the claim register with `bus_re` high and a nonzero result clears that source's pending bit and marks it in service. An in-service source does not become pending again, even while its line stays high.
- R7: Writing a source number to the claim register of a hart that has it enabled releases the in-service mark. A still-high line is pending again two cycles later.
- R8: A completion write naming a source that is not enabled for that hart is ignored, and the source stays in service.
- R9: `ext_irq[h]` is registered. It follows a change of threshold, enable, priority or pending state one clock later.
- R10: Reads of unmapped offsets (for example 0x1000 and 0x2004) return 0, and writes to them change no register.
- R11: Reset clears all priorities, enables, thresholds, pending and in-service state, and both interrupt outputs.
- R12: A high source line that is not in service sets its pending bit at the next edge. The pending bit stays set after the line drops, until the source is claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Level interrupt lines, bit s is source s (bit 0 unused) |
| bus_addr | input | 32 | Byte offset from the block's base |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (enables claim side effects) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| ext_irq | output | 2 | Per-hart external interrupt level |

## Verification
Arbitration is tried with six source patterns, each against all eight threshold values:
- all lines high, which shows that the top priority wins;
- only priority-0 lines, which must never interrupt;
- a pair at adjacent low priorities, which shows the strict comparison at each threshold;
- four sources tied at priority 7, which shows that the lowest number wins;
- a mixed spread of priorities;
- a single priority-0 line.

Each pattern is then drained through claim reads and completion writes after its lines are lowered, which exposes the claim order and the sticky pending bits. Separate sequences exercise:
- the one-cycle lag of the interrupt output;
- the in-service lock on a line that stays high;
- a completion write that is ignored because the source is not enabled for that hart;
- the independence of the two harts' enables and thresholds.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  // Byte offsets of the register regions from the block's base
  localparam int unsigned PRIO_BASE  = 32'h0000_0000;
  localparam int unsigned EN_BASE    = 32'h0000_2000;
  localparam int unsigned EN_STRIDE  = 32'h0000_0080;
  localparam int unsigned CTX_BASE   = 32'h0020_0000;
  localparam int unsigned CTX_STRIDE = 32'h0000_1000;
  localparam int unsigned CLAIM_OFS  = 32'h0000_0004;
endpackage

// File: rtl/irq_hub_srcs.sv
module irq_hub_srcs #(
  parameter int unsigned NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] claim_mask,
  input  logic [NSRC-1:0] done_mask,
  output logic [NSRC-1:0] pend_o,
  output logic [NSRC-1:0] actv_o
);
  localparam logic [NSRC-1:0] LIVE = {{(NSRC-1){1'b1}}, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_o <= '0;
      actv_o <= '0;
    end else begin
      pend_o <= (pend_o | (src_i & ~actv_o & LIVE)) & ~claim_mask;
      actv_o <= (actv_o | claim_mask) & ~done_mask;
    end
  end
endmodule

// File: rtl/irq_hub_pick.sv
module irq_hub_pick #(
  parameter int unsigned NSRC   = 32,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned ID_W   = 5
) (
  input  logic [NSRC-1:0]             cand_i,
  input  logic [NSRC-1:0][PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]           thr_i,
  output logic [ID_W-1:0]             id_o
);
  logic [PRIO_W-1:0] best;

  // Ascending scan with a strict compare keeps the lowest number on ties
  always_comb begin
    best = thr_i;
    id_o = '0;
    for (int s = 1; s < NSRC; s++) begin
      if (cand_i[s] && (prio_i[s] > best)) begin
        best = prio_i[s];
        id_o = ID_W'(s);
      end
    end
  end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int unsigned NSRC   = 32,
  parameter int unsigned NHART  = 2,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NHART-1:0]  ext_irq
);
  localparam int unsigned ID_W = $clog2(NSRC);
  localparam logic [NSRC-1:0] LIVE = {{(NSRC-1){1'b1}}, 1'b0};

  logic [NSRC-1:0][PRIO_W-1:0]  prio_q;
  logic [NHART-1:0][NSRC-1:0]   en_q;
  logic [NHART-1:0][PRIO_W-1:0] thr_q;
  logic [NHART-1:0][ID_W-1:0]   win;
  logic [NHART-1:0]             en_hit, thr_hit, clm_hit;
  logic                         prio_hit, done_ok;
  logic [ID_W-1:0]              prio_idx, done_id;
  logic [NSRC-1:0]              pend, actv, claim_mask, done_mask;

  // Address decode
  assign prio_idx = bus_addr[ID_W+1:2];
  assign prio_hit = (bus_addr[1:0] == 2'b00)
                  && ((bus_addr - ADDR_W'(PRIO_BASE)) >> 2) < ADDR_W'(NSRC);
  assign done_id  = bus_wdata[ID_W-1:0];
  assign done_ok  = bus_we && (bus_wdata < DATA_W'(NSRC));

  always_comb begin
    for (int h = 0; h < NHART; h++) begin
      en_hit[h]  = bus_addr == ADDR_W'(EN_BASE + h * EN_STRIDE);
      thr_hit[h] = bus_addr == ADDR_W'(CTX_BASE + h * CTX_STRIDE);
      clm_hit[h] = bus_addr == ADDR_W'(CTX_BASE + h * CTX_STRIDE + CLAIM_OFS);
    end
  end

  // Configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
    end else if (bus_we) begin
      if (prio_hit && (prio_idx != '0)) prio_q[prio_idx] <= bus_wdata[PRIO_W-1:0];
      for (int h = 0; h < NHART; h++) begin
        if (en_hit[h])  en_q[h]  <= bus_wdata[NSRC-1:0] & LIVE;
        if (thr_hit[h]) thr_q[h] <= bus_wdata[PRIO_W-1:0];
      end
    end
  end

  // Claim and completion strobes toward the source state
  always_comb begin
    claim_mask = '0;
    done_mask  = '0;
    for (int h = 0; h < NHART; h++) begin
      if (bus_re && clm_hit[h] && (win[h] != '0)) claim_mask[win[h]] = 1'b1;
      if (done_ok && clm_hit[h] && en_q[h][done_id]) done_mask[done_id] = 1'b1;
    end
  end

  irq_hub_srcs #(.NSRC(NSRC)) u_srcs (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_i      (src_i),
    .claim_mask (claim_mask),
    .done_mask  (done_mask),
    .pend_o     (pend),
    .actv_o     (actv)
  );

  for (genvar g = 0; g < NHART; g++) begin : g_ctx
    irq_hub_pick #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_pick (
      .cand_i (pend & en_q[g]),
      .prio_i (prio_q),
      .thr_i  (thr_q[g]),
      .id_o   (win[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_irq <= '0;
    end else begin
      for (int h = 0; h < NHART; h++) ext_irq[h] <= (win[h] != '0);
    end
  end

  // Read data
  always_comb begin
    bus_rdata = '0;
    if (prio_hit) bus_rdata = DATA_W'(prio_q[prio_idx]);
    for (int h = 0; h < NHART; h++) begin
      if (en_hit[h])  bus_rdata = DATA_W'(en_q[h]);
      if (thr_hit[h]) bus_rdata = DATA_W'(thr_q[h]);
      if (clm_hit[h]) bus_rdata = DATA_W'(win[h]);
    end
  end
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
  parameter int unsigned NSRC   = 32,
  parameter int unsigned NHART  = 2,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ID_W   = 5
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         bus_we,
  input logic                         bus_re,
  input logic [DATA_W-1:0]            bus_wdata,
  input logic [NHART-1:0]             ext_irq,
  input logic [NHART-1:0]             clm_hit,
  input logic [NSRC-1:0]              pend,
  input logic [NSRC-1:0]              actv,
  input logic [NSRC-1:0][PRIO_W-1:0]  prio_q,
  input logic [NHART-1:0][NSRC-1:0]   en_q,
  input logic [NHART-1:0][PRIO_W-1:0] thr_q,
  input logic [NHART-1:0][ID_W-1:0]   win
);
  AST_SVC_NOT_PEND: assert property (@(posedge clk) disable iff (!rst_n) (pend & actv) == '0); // R6
  AST_SRC0_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !pend[0] && !actv[0] && (prio_q[0] == '0)); // R1

  for (genvar g = 0; g < NHART; g++) begin : g_hart
    AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n) (win[g] != '0) |-> (pend[win[g]] && en_q[g][win[g]] && (prio_q[win[g]] > thr_q[g]))); // R4
    AST_CLAIM_LOCKS: assert property (@(posedge clk) disable iff (!rst_n) (bus_re && clm_hit[g] && (win[g] != '0)) |=> (actv[$past(win[g])] && !pend[$past(win[g])])); // R6
    AST_DONE_GATED: assert property (@(posedge clk) disable iff (!rst_n) (bus_we && !bus_re && clm_hit[g] && !en_q[g][bus_wdata[ID_W-1:0]]) |=> (actv[$past(bus_wdata[ID_W-1:0])] == $past(actv[bus_wdata[ID_W-1:0]]))); // R8
    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) (win[g] != '0) |=> ext_irq[g]); // R9
  end
endmodule

bind irq_hub irq_hub_chk #(
  .NSRC(NSRC), .NHART(NHART), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .ID_W(ID_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_re    (bus_re),
  .bus_wdata (bus_wdata),
  .ext_irq   (ext_irq),
  .clm_hit   (clm_hit),
  .pend      (pend),
  .actv      (actv),
  .prio_q    (prio_q),
  .en_q      (en_q),
  .thr_q     (thr_q),
  .win       (win)
);

// File: tb/test_irq_hub.sv
module test_irq_hub;
  localparam logic [31:0] EN0  = 32'h0000_2000;
  localparam logic [31:0] EN1  = 32'h0000_2080;
  localparam logic [31:0] THR0 = 32'h0020_0000;
  localparam logic [31:0] THR1 = 32'h0020_1000;
  localparam logic [31:0] CLM0 = 32'h0020_0004;
  localparam logic [31:0] CLM1 = 32'h0020_1004;
  localparam logic [31:0] IDLE = 32'h0001_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic [31:0] addr = IDLE;
  logic        we = 1'b0;
  logic        re = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  ext_irq;
  int checks = 0;
  int errors = 0;
  int prio_m [32];

  always #10 clk = ~clk;

  irq_hub i_irq_hub (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(addr), .bus_we(we),
    .bus_re(re), .bus_wdata(wdata), .bus_rdata(rdata), .ext_irq(ext_irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; addr = IDLE;
  endtask

  task automatic rd(logic [31:0] a, logic take, output logic [31:0] d);
    @(negedge clk);
    addr = a; re = take;
    #2 d = rdata;
    @(negedge clk);
    re = 1'b0; addr = IDLE;
  endtask

  // Highest level first, lowest number first within a level
  function automatic int exp_win(logic [31:0] p, logic [31:0] e, int t);
    for (int lvl = 7; lvl > t; lvl--)
      for (int s = 1; s < 32; s++)
        if (p[s] && e[s] && prio_m[s] == lvl) return s;
    return 0;
  endfunction

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] pats [6];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0000_0100; pats[2] = 32'h0000_0600;
    pats[3] = 32'h8080_8080; pats[4] = 32'h0101_0100; pats[5] = 32'h0000_4422;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    check("R11 irq", {30'd0, ext_irq}, 32'h0);
    rd(32'h14, 1'b0, d); check("R11 prio", d, 0);
    rd(EN0, 1'b0, d);    check("R11 enable", d, 0);
    rd(THR1, 1'b0, d);   check("R11 threshold", d, 0);
    rd(CLM0, 1'b1, d);   check("R11 claim", d, 0);

    // R10 unmapped
    wr(32'h1000, 32'hFFFF_FFFF);
    wr(32'h2004, 32'hFFFF_FFFF);
    rd(32'h1000, 1'b0, d); check("R10 read 0x1000", d, 0);
    rd(32'h2004, 1'b0, d); check("R10 read 0x2004", d, 0);
    rd(EN0, 1'b0, d);      check("R10 enable untouched", d, 0);
    rd(THR0, 1'b0, d);     check("R10 threshold untouched", d, 0);

    // R1 priority sweep
    for (int s = 0; s < 32; s++) begin
      wr(32'(s * 4), 32'hFFFF_FFF8 | 32'(s % 8));
      prio_m[s] = (s == 0) ? 0 : s % 8;
    end
    for (int s = 0; s < 32; s++) begin
      rd(32'(s * 4), 1'b0, d); check("R1 priority readback", d, 32'(prio_m[s]));
    end

    // R2 and R3
    wr(EN0, 32'hFFFF_FFFF);
    rd(EN0, 1'b0, d); check("R2 enable bit0 clear", d, 32'hFFFF_FFFE);
    rd(EN1, 1'b0, d); check("R2 other hart separate", d, 0);
    wr(THR0, 32'hFD);
    rd(THR0, 1'b0, d); check("R3 threshold field", d, 5);

    // R4 R5 R9 sweep, then R6 R12 drain
    for (int i = 0; i < 6; i++) begin
      logic [31:0] p;
      src_i = pats[i];
      repeat (3) @(negedge clk);
      for (int t = 0; t < 8; t++) begin
        int e;
        wr(THR0, 32'(t));
        e = exp_win(pats[i], 32'hFFFF_FFFF, t);
        rd(CLM0, 1'b0, d);
        check("R5 winner", d, 32'(e));
        check("R4 R9 irq hart0", {31'd0, ext_irq[0]}, {31'd0, e != 0});
        check("R4 irq hart1 off", {31'd0, ext_irq[1]}, 0);
      end
      wr(THR0, 0);
      src_i = '0;
      p = pats[i];
      for (int k = 0; k < 33; k++) begin
        int e;
        e = exp_win(p, 32'hFFFF_FFFF, 0);
        rd(CLM0, 1'b1, d);
        check("R6 R12 claim order", d, 32'(e));
        if (e == 0) break;
        p[e] = 1'b0;
        wr(CLM0, 32'(e));
      end
    end

    // R9 one-cycle lag on source 5 (priority 5)
    src_i = 32'h20;
    repeat (3) @(negedge clk);
    check("R9 irq raised", {31'd0, ext_irq[0]}, 1);
    wr(THR0, 5);
    check("R9 irq before lag", {31'd0, ext_irq[0]}, 1);
    @(negedge clk);
    check("R9 irq after lag", {31'd0, ext_irq[0]}, 0);
    wr(THR0, 0);
    check("R9 irq before lag rise", {31'd0, ext_irq[0]}, 0);
    @(negedge clk);
    check("R9 irq after lag rise", {31'd0, ext_irq[0]}, 1);

    // R6 in-service lock, R8 ignored completion, R7 release
    rd(CLM0, 1'b1, d); check("R6 claim source 5", d, 5);
    repeat (2) @(negedge clk);
    rd(CLM0, 1'b0, d); check("R6 locked while high", d, 0);
    check("R6 irq low while locked", {31'd0, ext_irq[0]}, 0);
    wr(EN0, 32'hFFFF_FFDF);
    wr(CLM0, 5);
    wr(EN0, 32'hFFFF_FFFF);
    repeat (2) @(negedge clk);
    rd(CLM0, 1'b0, d); check("R8 completion ignored", d, 0);
    wr(CLM0, 5);
    repeat (2) @(negedge clk);
    rd(CLM0, 1'b0, d); check("R7 pending again", d, 5);
    src_i = '0;
    rd(CLM0, 1'b1, d); check("R7 claim again", d, 5);
    wr(CLM0, 5);

    // R4 per-hart enable and strict threshold on hart 1, source 9 (priority 1)
    wr(EN0, 0);
    wr(EN1, 32'h200);
    rd(EN1, 1'b0, d); check("R2 hart1 stride", d, 32'h200);
    src_i = 32'h200;
    repeat (3) @(negedge clk);
    check("R4 hart1 only", {30'd0, ext_irq}, 32'h2);
    rd(CLM1, 1'b0, d); check("R5 hart1 winner", d, 9);
    rd(CLM0, 1'b0, d); check("R4 hart0 disabled", d, 0);
    wr(THR1, 1);
    @(negedge clk);
    check("R4 strict threshold irq", {30'd0, ext_irq}, 0);
    rd(CLM1, 1'b0, d); check("R4 strict threshold claim", d, 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule